// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This peripheral watches for a stalled system. Its input clock first goes through a programmable linear divider (divide by prescale+1, from 1 to 256). The result then goes through a power-of-two stage that divides by 16, 32, 64 or 128. Each tick from the second stage moves a 16-bit down-counter one step. When the counter runs out, it reloads from a reload-data register. If the timer enable and the reset enable are both set at that moment, the block also drives a fixed-length system reset pulse.

Software uses three word-aligned registers on a simple 32-bit write/read bus. The control register is at 0x0, the reload-data register at 0x4 and the live count at 0x8. Software services the watchdog by writing the count register, which restarts the countdown. To force a reset quickly, software clears the enables, writes 1 to the count and then sets both enables again. The reload-data register can only be changed while the timer is stopped.

Top module: `wdog_timer`

## Requirements
- R1: After the synchronous reset, the control register reads 0x0000_0000. The reload-data and count registers both read 0x0000_8000, and `sys_rst_o` is low.
- R2: Control bits 15:8 hold the prescale value p and bits 4:3 hold the select value s. While the timer runs, a counting tick occurs once every (p+1)·(16<<s) input clock cycles.
- R3: Each tick lowers the count by one. A count of N runs out on the (N+1)-th tick, and on that tick the count takes the reload-data value.
- R4: A bus write to offset 0x8 loads bits 15:0 into the count on that edge and restarts both divider stages. This write takes priority over a tick that falls on the same edge.
- R5: Control bit 5 is the timer enable and bit 0 is the reset enable. When the count runs out, `sys_rst_o` goes high for exactly 16 clock cycles, but only if both bits are set. If bit 0 is clear, the count reloads and no pulse is driven.
- R6: While bit 5 is clear, the count and the dividers hold still and no new reset pulse can start, whatever the value of bit 0.
- R7: A write to the reload-data register at offset 0x4 is ignored while bit 5 is set. While bit 5 is clear, the write stores bits 15:0.
- R8: Control bits other than 15:8, 5, 4:3 and 0 read as zero. A read of an unmapped offset (0xC) returns zero.
- R9: The sequence "clear the enables, write count 1, set both enables" with p and s produces a reset pulse exactly 2·(p+1)·(16<<s) cycles after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Two events can land on the same edge: a software service write to the count register and a divider tick, which may also be the tick that ends the count. To provoke this, the bench times a count write so that its bus edge is exactly the sixteenth enabled edge, where the first tick falls with the fastest divider setting. The result is judged from the count read back at once and then one tick period later. The written value must appear unchanged and then go down by exactly one after a full fresh period. That shows the write won and the dividers restarted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CNT_W     = 16;
    localparam int PRE_W     = 8;
    localparam int SEL_W     = 2;
    localparam int BASE_LOG2 = 4;
    localparam int PULSE_LEN = 16;
    localparam int DIV_W     = BASE_LOG2 + (1 << SEL_W) - 1;

    localparam logic [CNT_W-1:0] CNT_RESET = 16'h8000;

    // control word bit positions
    localparam int CTL_RST_BIT = 0;
    localparam int CTL_SEL_LO  = 3;
    localparam int CTL_EN_BIT  = 5;
    localparam int CTL_PRE_LO  = 8;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic             tmr_en;
        logic [SEL_W-1:0] clk_sel;
        logic             rst_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.prescale = w[CTL_PRE_LO +: PRE_W];
        c.tmr_en   = w[CTL_EN_BIT];
        c.clk_sel  = w[CTL_SEL_LO +: SEL_W];
        c.rst_en   = w[CTL_RST_BIT];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CTL_PRE_LO +: PRE_W] = c.prescale;
        w[CTL_EN_BIT]          = c.tmr_en;
        w[CTL_SEL_LO +: SEL_W] = c.clk_sel;
        w[CTL_RST_BIT]         = c.rst_en;
        return w;
    endfunction

    function automatic reg_sel_e decode_addr(input logic [3:0] a);
        reg_sel_e r;
        if (a[1:0] != 2'b00) begin
            r = REG_NONE;
        end else begin
            case (a[3:2])
                2'd0:    r = REG_CTRL;
                2'd1:    r = REG_RELOAD;
                2'd2:    r = REG_COUNT;
                default: r = REG_NONE;
            endcase
        end
        return r;
    endfunction

    // terminal value of the power-of-two stage: (16 << sel) - 1
    function automatic logic [DIV_W-1:0] div_limit(input logic [SEL_W-1:0] sel);
        logic [DIV_W:0] one;
        logic [DIV_W:0] full;
        one  = 1;
        full = one << (BASE_LOG2 + int'(sel));
        full = full - one;
        return full[DIV_W-1:0];
    endfunction

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [3:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic [CW-1:0] cnt_live,
    output ctrl_t         ctrl_q,
    output logic [CW-1:0] reload_q,
    output logic          cnt_wr,
    output logic [CW-1:0] cnt_wval,
    output logic          reload_try,
    output logic [31:0]   bus_rdata
);

    reg_sel_e wsel;
    reg_sel_e rsel;
    logic     wr;

    assign wr         = bus_sel && bus_we;
    assign wsel       = decode_addr(bus_addr);
    assign rsel       = decode_addr(bus_addr);
    assign cnt_wr     = wr && (wsel == REG_COUNT);
    assign reload_try = wr && (wsel == REG_RELOAD);
    assign cnt_wval   = bus_wdata[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= CNT_RESET[CW-1:0];
        end else begin
            if (wr && wsel == REG_CTRL) begin
                ctrl_q <= ctrl_from_word(bus_wdata);
            end
            // reload data is locked while the timer runs
            if (reload_try && !ctrl_q.tmr_en) begin
                reload_q <= bus_wdata[CW-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            REG_CTRL:   bus_rdata = ctrl_to_word(ctrl_q);
            REG_RELOAD: bus_rdata[CW-1:0] = reload_q;
            REG_COUNT:  bus_rdata[CW-1:0] = cnt_live;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_tickgen.sv
module wdog_tickgen
    import wdog_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int SW = SEL_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  logic [PW-1:0] prescale,
    input  logic [SW-1:0] clk_sel,
    output logic          tick
);

    logic [PW-1:0] pre_cnt;
    logic [DW-1:0] div_cnt;
    logic [DW-1:0] lim;
    logic          pre_hit;

    assign lim     = div_limit(clk_sel);
    assign pre_hit = run && (pre_cnt == prescale);
    assign tick    = pre_hit && (div_cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            if (pre_hit) begin
                pre_cnt <= '0;
                div_cnt <= (div_cnt >= lim) ? '0 : div_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cnt,
    output logic          expire
);

    assign expire = tick && !load && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_RESET[CW-1:0];
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);

    localparam int LW = $clog2(LEN + 1);
    localparam logic [LW-1:0] LEN_V = LW'(LEN);

    logic [LW-1:0] remain;

    assign pulse = (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (fire) begin
            remain <= LEN_V;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int PLS = PULSE_LEN
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sys_rst_o
);

    ctrl_t         ctrl_q;
    logic [CW-1:0] reload_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_wval;
    logic          cnt_wr;
    logic          reload_try;
    logic          tick;
    logic          expire;
    logic          fire;

    wdog_regfile #(.CW(CW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_live   (cnt_q),
        .ctrl_q     (ctrl_q),
        .reload_q   (reload_q),
        .cnt_wr     (cnt_wr),
        .cnt_wval   (cnt_wval),
        .reload_try (reload_try),
        .bus_rdata  (bus_rdata)
    );

    wdog_tickgen u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.tmr_en),
        .restart  (cnt_wr),
        .prescale (ctrl_q.prescale),
        .clk_sel  (ctrl_q.clk_sel),
        .tick     (tick)
    );

    wdog_downcount #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_wr),
        .load_val (cnt_wval),
        .tick     (tick),
        .reload   (reload_q),
        .cnt      (cnt_q),
        .expire   (expire)
    );

    assign fire = expire && ctrl_q.tmr_en && ctrl_q.rst_en;

    wdog_rst_stretch #(.LEN(PLS)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .pulse (sys_rst_o)
    );

endmodule

// File: rtl/wdog_timer_checker.sv
module wdog_timer_checker #(
    parameter int CW  = 16,
    parameter int PLS = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tmr_en,
    input logic          rst_en,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] reload,
    input logic          cnt_wr,
    input logic [CW-1:0] cnt_wval,
    input logic          reload_try,
    input logic          expire,
    input logic          sys_rst
);

    logic [7:0] since_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_fire <= 8'hFF;
        end else if (expire && tmr_en && rst_en) begin
            since_fire <= '0;
        end else if (since_fire != 8'hFF) begin
            since_fire <= since_fire + 1'b1;
        end
    end

    p_pulse_needs_both_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |-> $past(tmr_en && rst_en));

    p_pulse_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst) |-> (since_fire == 8'(PLS)));

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!tmr_en && !cnt_wr) |=> $stable(cnt));

    p_reload_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (tmr_en && reload_try) |=> $stable(reload));

    p_count_write_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(cnt_wval)));

    p_expire_reload_r3: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == $past(reload)));

endmodule

bind wdog_timer wdog_timer_checker #(.CW(CW), .PLS(PLS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tmr_en     (ctrl_q.tmr_en),
    .rst_en     (ctrl_q.rst_en),
    .cnt        (cnt_q),
    .reload     (reload_q),
    .cnt_wr     (cnt_wr),
    .cnt_wval   (cnt_wval),
    .reload_try (reload_try),
    .expire     (expire),
    .sys_rst    (sys_rst_o)
);

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    wdog_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sys_rst_o (sys_rst_o)
    );

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_RLD  = 4'h4;
    localparam logic [3:0] A_CNT  = 4'h8;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // advance k edges, counting samples where the reset output is high
    task automatic run(input int k, output int highs);
        highs = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (sys_rst_o) highs++;
        end
    endtask

    task automatic t_reset_state;
        logic [31:0] d;
        rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
        rd(A_RLD, d);  check("R1 reload", d, 32'h8000);
        rd(A_CNT, d);  check("R1 count", d, 32'h8000);
        check("R1 sys_rst", {31'b0, sys_rst_o}, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d);
        wr(A_CTRL, 32'h0);
        check("R8 ctrl fields", d, 32'h0000_FF39);
        rd(4'hC, d); check("R8 unmapped", d, 32'h0);
        wr(A_CNT, 32'h0000_8000);
    endtask

    // p=2, s=1: period 96; reset enable clear
    task automatic t_prescale_count;
        logic [31:0] d;
        int h;
        int tot;
        wr(A_RLD, 32'h3);
        wr(A_CNT, 32'h2);
        wr(A_CTRL, 32'h0000_0228);
        tot = 0;
        run(95, h); tot += h;
        rd(A_CNT, d); check("R2 count before first tick", d, 32'h2);
        run(1, h); tot += h;
        rd(A_CNT, d); check("R2 first tick at 96", d, 32'h1);
        run(96, h); tot += h;
        rd(A_CNT, d); check("R3 second tick", d, 32'h0);
        run(96, h); tot += h;
        rd(A_CNT, d); check("R3 expiry reloads", d, 32'h3);
        run(20, h); tot += h;
        check("R5 no pulse without reset enable", tot, 0);
        wr(A_CTRL, 32'h0);
    endtask

    // p=0, s=0, count 1: expiry 32 edges after enable
    task automatic t_pulse;
        logic [31:0] d;
        int h;
        wr(A_CNT, 32'h1);
        wr(A_CTRL, 32'h21);
        run(31, h);
        check("R5 no early pulse", h, 0);
        run(1, h);
        check("R5 pulse starts", {31'b0, sys_rst_o}, 32'h1);
        rd(A_CNT, d); check("R3 reload after expiry", d, 32'h3);
        run(19, h);
        check("R5 pulse width", h + 1, 16);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_reload_lock;
        logic [31:0] d;
        wr(A_CTRL, 32'h20);
        wr(A_RLD, 32'h1234);
        rd(A_RLD, d); check("R7 locked while enabled", d, 32'h3);
        wr(A_CTRL, 32'h0);
        wr(A_RLD, 32'h1234);
        rd(A_RLD, d); check("R7 written while disabled", d, 32'h1234);
        wr(A_RLD, 32'h3);
    endtask

    task automatic t_frozen;
        logic [31:0] d;
        int h;
        wr(A_CNT, 32'h5);
        run(300, h);
        rd(A_CNT, d); check("R6 frozen when disabled", d, 32'h5);
        wr(A_CTRL, 32'h01);
        wr(A_CNT, 32'h0);
        run(300, h);
        rd(A_CNT, d); check("R6 frozen with only reset enable", d, 32'h0);
        check("R6 no pulse while disabled", h, 0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_service;
        int h;
        int tot;
        wr(A_CNT, 32'h1);
        wr(A_CTRL, 32'h21);
        tot = 0;
        for (int i = 0; i < 10; i++) begin
            run(19, h); tot += h;
            wr(A_CNT, 32'h1);
        end
        run(20, h); tot += h;
        check("R4 servicing prevents reset", tot, 0);
        wr(A_CTRL, 32'h0);
    endtask

    // count write on the edge of the first tick
    task automatic t_collision;
        logic [31:0] d;
        int h;
        wr(A_CNT, 32'h5);
        wr(A_CTRL, 32'h21);
        run(15, h);
        wr(A_CNT, 32'h7);
        rd(A_CNT, d); check("R4 write wins over tick", d, 32'h7);
        run(15, h);
        rd(A_CNT, d); check("R4 dividers restarted", d, 32'h7);
        run(1, h);
        rd(A_CNT, d); check("R4 tick one period after write", d, 32'h6);
        wr(A_CTRL, 32'h0);
    endtask

    // p=5, s=0: period 96, pulse 192 edges after enabling write
    task automatic t_force;
        int h;
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'h1);
        wr(A_CTRL, 32'h0000_0521);
        run(191, h);
        check("R9 no pulse before 192", h, 0);
        run(1, h);
        check("R9 pulse at 192", {31'b0, sys_rst_o}, 32'h1);
        wr(A_CTRL, 32'h0);
        run(20, h);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state;
        t_map;
        t_prescale_count;
        t_pulse;
        t_reload_lock;
        t_frozen;
        t_service;
        t_collision;
        t_force;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule